// File: doc/BRIEF.md
# Ethernet PAUSE Frame Generator

This block sits on the transmit side of an Ethernet MAC and issues flow-control PAUSE frames when the receiver is running short of buffer space. It watches three kinds of trigger: a near-full flag from the receive FIFO, two software command bits, and two request pins. From these it decides whether the link partner should be told to stop (XOFF, with the configured quanta) or to resume (XON, zero quanta).

A request is latched until its frame goes out. A frame never starts while a normal transmit frame is in progress. Once it starts, the block drives a byte stream of one byte per clock. The stream has start-of-frame and end-of-frame markers and is zero-padded to the minimum length without the FCS, which a later stage appends. A busy output covers the whole frame so that the normal transmit path stays off the line.

Top module: `flowctl_pause_tx`

## Requirements
- R1: While reset is asserted and whenever no frame is being sent, `pf_busy`, `pf_valid`, `pf_sop` and `pf_eop` are 0 and `pf_data` is 0x00.
- R2: A 0-to-1 transition of `rxq_near_full` queues an XOFF frame, whose two quanta bytes carry `quanta_cfg`.
- R3: A 1-to-0 transition of `rxq_near_full` queues an XON frame, whose two quanta bytes are 0x00 0x00.
- R4: A queued frame starts only at a clock edge where `tx_active` is sampled 0. The first byte appears in the cycle after that edge.
- R5: Byte order is fixed, with byte 0 first. Bytes 0-5 are the destination 01 80 C2 00 00 01. Bytes 6-11 are the source address `{station_hi, station_lo}` with bits 47:40 first. Bytes 12-13 are 0x88 0x08 and bytes 14-15 are 0x00 0x01. Byte 16 is quanta bits 15:8 and byte 17 is quanta bits 7:0.
- R6: A frame is FRAME_LEN (60) consecutive bytes, one per cycle, with bytes 18 onward 0x00. `pf_sop` marks byte 0 and `pf_eop` marks byte FRAME_LEN-1.
- R7: A 0-to-1 transition of the XOFF request level, which is the OR of `cmd_xoff` and `req_xoff`, queues an XOFF frame.
- R8: An XON trigger is ignored while the XOFF request level is 1. An XON trigger is either a 0-to-1 transition of the OR of `cmd_xon` and `req_xon`, or a fall of `rxq_near_full`. If XOFF and XON triggers arrive in the same cycle, only XOFF is queued.
- R9: Each trigger transition yields at most one frame, and a level held high yields no more. A trigger arriving while a frame is being sent is kept and sent after it.
- R10: `pf_busy` and `pf_valid` stay 1 from byte 0 to byte FRAME_LEN-1 with no gap, and fall in the cycle after `pf_eop`. A started frame is never cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxq_near_full | input | 1 | Receive FIFO section threshold flag |
| cmd_xoff | input | 1 | Software XOFF command bit (level) |
| cmd_xon | input | 1 | Software XON command bit (level) |
| req_xoff | input | 1 | XOFF request pin |
| req_xon | input | 1 | XON request pin |
| tx_active | input | 1 | A normal transmit frame is in progress |
| station_lo | input | 32 | Source address bits 31:0 |
| station_hi | input | 16 | Source address bits 47:32 |
| quanta_cfg | input | 16 | Pause time placed in XOFF frames |
| pf_valid | output | 1 | `pf_data` carries a frame byte |
| pf_data | output | 8 | Frame byte |
| pf_sop | output | 1 | First byte of the frame |
| pf_eop | output | 1 | Last byte of the frame |
| pf_busy | output | 1 | Pause frame occupies the transmit path |

## Verification
The bound checker watches the framing on every cycle. It checks that a frame opens with a start marker and the multicast first byte, and that it never begins right after a cycle with `tx_active` high. It also checks that busy stays up until the end marker, that the end marker lands exactly on the last byte position, and that the outputs are quiet between frames. The byte contents beyond the first, the choice between XOFF and XON, the same-cycle priority, the blocking of XON while XOFF is held, and the rule of one frame per transition depend on the history of the triggers. Only the bench's reference model and its scenarios show those.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

    localparam int          HDR_LEN    = 18;
    localparam logic [47:0] PAUSE_DA   = 48'h0180_C200_0001;
    localparam logic [15:0] MAC_CTL_ET = 16'h8808;
    localparam logic [15:0] PAUSE_OPC  = 16'h0001;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_SEND = 1'b1
    } seq_state_e;

endpackage

// File: rtl/pfg_req_latch.sv
module pfg_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic near_full,
    input  logic xoff_lvl,
    input  logic xon_lvl,
    input  logic take,
    output logic pend_xoff,
    output logic pend_xon
);

    typedef struct packed {
        logic full_prev;
        logic xoff_prev;
        logic xon_prev;
        logic p_xoff;
        logic p_xon;
    } req_t;

    req_t r_d, r_q;
    logic xoff_ev;
    logic xon_ev;

    always_comb begin
        xoff_ev = (near_full & ~r_q.full_prev) | (xoff_lvl & ~r_q.xoff_prev);
        xon_ev  = ~xoff_lvl & ((~near_full & r_q.full_prev) | (xon_lvl & ~r_q.xon_prev));

        r_d           = r_q;
        r_d.full_prev = near_full;
        r_d.xoff_prev = xoff_lvl;
        r_d.xon_prev  = xon_lvl;

        if (take) begin
            r_d.p_xoff = 1'b0;
            r_d.p_xon  = 1'b0;
        end
        if (xoff_ev) begin
            r_d.p_xoff = 1'b1;
            r_d.p_xon  = 1'b0;
        end else if (xon_ev) begin
            r_d.p_xon  = 1'b1;
            r_d.p_xoff = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pend_xoff = r_q.p_xoff;
    assign pend_xon  = r_q.p_xon;

endmodule

// File: rtl/pfg_seq.sv
module pfg_seq #(
    parameter  int FRAME_LEN = 60,
    parameter  int QUANTA_W  = 16,
    parameter  int ADDR_W    = 48,
    localparam int IDX_W     = $clog2(FRAME_LEN)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pend_xoff,
    input  logic                pend_xon,
    input  logic                tx_active,
    input  logic [ADDR_W-1:0]   src_addr,
    input  logic [QUANTA_W-1:0] quanta,
    output logic                take,
    output logic [IDX_W-1:0]    idx,
    output logic                kind_xoff,
    output logic [ADDR_W-1:0]   addr_s,
    output logic [QUANTA_W-1:0] quanta_s,
    output logic                busy,
    output logic                sop,
    output logic                eop
);
    import pfg_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

    typedef struct packed {
        seq_state_e          state;
        logic [IDX_W-1:0]    cnt;
        logic                xoff;
        logic [ADDR_W-1:0]   addr;
        logic [QUANTA_W-1:0] quanta;
    } seq_t;

    seq_t s_d, s_q;
    logic start;

    always_comb begin
        start = (s_q.state == SEQ_IDLE) && (pend_xoff || pend_xon) && !tx_active;
        s_d   = s_q;
        case (s_q.state)
            SEQ_IDLE: begin
                if (start) begin
                    s_d.state  = SEQ_SEND;
                    s_d.cnt    = '0;
                    s_d.xoff   = pend_xoff;
                    s_d.addr   = src_addr;
                    s_d.quanta = quanta;
                end
            end
            SEQ_SEND: begin
                if (s_q.cnt == LAST_IDX) begin
                    s_d.state = SEQ_IDLE;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign take      = start;
    assign idx       = s_q.cnt;
    assign kind_xoff = s_q.xoff;
    assign addr_s    = s_q.addr;
    assign quanta_s  = s_q.quanta;
    assign busy      = (s_q.state == SEQ_SEND);
    assign sop       = busy && (s_q.cnt == '0);
    assign eop       = busy && (s_q.cnt == LAST_IDX);

endmodule

// File: rtl/pfg_byte_sel.sv
module pfg_byte_sel #(
    parameter  int FRAME_LEN = 60,
    parameter  int QUANTA_W  = 16,
    parameter  int ADDR_W    = 48,
    localparam int IDX_W     = $clog2(FRAME_LEN)
) (
    input  logic [IDX_W-1:0]    idx,
    input  logic                enable,
    input  logic                kind_xoff,
    input  logic [ADDR_W-1:0]   src_addr,
    input  logic [QUANTA_W-1:0] quanta,
    output logic [7:0]          byte_o
);
    import pfg_pkg::*;

    localparam int HDR_BITS = 8 * HDR_LEN;

    logic [QUANTA_W-1:0] q_eff;
    logic [HDR_BITS-1:0] hdr;
    logic [7:0]          hdr_byte [HDR_LEN];

    assign q_eff = kind_xoff ? quanta : '0;
    assign hdr   = {PAUSE_DA, src_addr, MAC_CTL_ET, PAUSE_OPC, q_eff};

    for (genvar g = 0; g < HDR_LEN; g++) begin : g_hdr
        assign hdr_byte[g] = hdr[8*(HDR_LEN-1-g) +: 8];
    end

    always_comb begin
        byte_o = '0;
        if (enable) begin
            for (int i = 0; i < HDR_LEN; i++) begin
                if (idx == IDX_W'(i)) begin
                    byte_o = hdr_byte[i];
                end
            end
        end
    end

endmodule

// File: rtl/flowctl_pause_tx.sv
module flowctl_pause_tx #(
    parameter int FRAME_LEN = 60,
    parameter int QUANTA_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rxq_near_full,
    input  logic                cmd_xoff,
    input  logic                cmd_xon,
    input  logic                req_xoff,
    input  logic                req_xon,
    input  logic                tx_active,
    input  logic [31:0]         station_lo,
    input  logic [15:0]         station_hi,
    input  logic [QUANTA_W-1:0] quanta_cfg,
    output logic                pf_valid,
    output logic [7:0]          pf_data,
    output logic                pf_sop,
    output logic                pf_eop,
    output logic                pf_busy
);
    localparam int ADDR_W = 48;
    localparam int IDX_W  = $clog2(FRAME_LEN);

    logic                pend_xoff, pend_xon, take;
    logic [IDX_W-1:0]    idx;
    logic                kind_xoff, busy;
    logic [ADDR_W-1:0]   addr_s;
    logic [QUANTA_W-1:0] quanta_s;

    pfg_req_latch u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .near_full (rxq_near_full),
        .xoff_lvl  (cmd_xoff | req_xoff),
        .xon_lvl   (cmd_xon | req_xon),
        .take      (take),
        .pend_xoff (pend_xoff),
        .pend_xon  (pend_xon)
    );

    pfg_seq #(
        .FRAME_LEN (FRAME_LEN),
        .QUANTA_W  (QUANTA_W),
        .ADDR_W    (ADDR_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_xoff (pend_xoff),
        .pend_xon  (pend_xon),
        .tx_active (tx_active),
        .src_addr  ({station_hi, station_lo}),
        .quanta    (quanta_cfg),
        .take      (take),
        .idx       (idx),
        .kind_xoff (kind_xoff),
        .addr_s    (addr_s),
        .quanta_s  (quanta_s),
        .busy      (busy),
        .sop       (pf_sop),
        .eop       (pf_eop)
    );

    pfg_byte_sel #(
        .FRAME_LEN (FRAME_LEN),
        .QUANTA_W  (QUANTA_W),
        .ADDR_W    (ADDR_W)
    ) u_bytes (
        .idx       (idx),
        .enable    (busy),
        .kind_xoff (kind_xoff),
        .src_addr  (addr_s),
        .quanta    (quanta_s),
        .byte_o    (pf_data)
    );

    assign pf_valid = busy;
    assign pf_busy  = busy;

endmodule

// File: rtl/pfg_checker.sv
module pfg_checker #(
    parameter int FRAME_LEN = 60
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_active,
    input logic       pf_valid,
    input logic [7:0] pf_data,
    input logic       pf_sop,
    input logic       pf_eop,
    input logic       pf_busy
);
    localparam int CW = $clog2(FRAME_LEN) + 1;

    logic [CW-1:0] beat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (!pf_busy) begin
            beat_q <= '0;
        end else begin
            beat_q <= beat_q + 1'b1;
        end
    end

    assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pf_busy |-> (!pf_valid && !pf_sop && !pf_eop && pf_data == 8'h00));

    assert_defer_tx_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_busy) |-> !$past(tx_active));

    assert_dest_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pf_sop |-> pf_data == 8'h01);

    assert_sop_on_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_busy) |-> pf_sop);

    assert_eop_position_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pf_eop |-> (beat_q == CW'(FRAME_LEN - 1)));

    assert_no_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_busy && !pf_eop) |=> pf_busy);

    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pf_eop |=> !pf_busy);

endmodule

bind flowctl_pause_tx pfg_checker #(.FRAME_LEN(FRAME_LEN)) u_pfg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_active (tx_active),
    .pf_valid  (pf_valid),
    .pf_data   (pf_data),
    .pf_sop    (pf_sop),
    .pf_eop    (pf_eop),
    .pf_busy   (pf_busy)
);

// File: tb/flowctl_pause_tx_test.sv
module flowctl_pause_tx_test;

    localparam int FLEN = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rxq_near_full = 1'b0;
    logic        cmd_xoff = 1'b0, cmd_xon = 1'b0, req_xoff = 1'b0, req_xon = 1'b0;
    logic        tx_active = 1'b0;
    logic [31:0] station_lo = 32'h2C3D_4E5F;
    logic [15:0] station_hi = 16'h0A1B;
    logic [15:0] quanta_cfg = 16'h1234;
    logic        pf_valid, pf_sop, pf_eop, pf_busy;
    logic [7:0]  pf_data;

    always #5 clk = ~clk;

    flowctl_pause_tx uut (
        .clk(clk), .rst_n(rst_n), .rxq_near_full(rxq_near_full),
        .cmd_xoff(cmd_xoff), .cmd_xon(cmd_xon), .req_xoff(req_xoff), .req_xon(req_xon),
        .tx_active(tx_active), .station_lo(station_lo), .station_hi(station_hi),
        .quanta_cfg(quanta_cfg), .pf_valid(pf_valid), .pf_data(pf_data),
        .pf_sop(pf_sop), .pf_eop(pf_eop), .pf_busy(pf_busy)
    );

    int    compared = 0;
    int    mismatched = 0;
    string cur_req = "R1";
    int    frames = 0;
    int    obs_idx = 0;
    logic [7:0] last_p1 = 8'h00;

    // behavioural reference: queue of bytes still to appear
    logic [7:0] exp_q[$];
    bit m_full_p, m_xoff_p, m_xon_p, m_px, m_pn;
    bit was_busy, xl, nl, xe, ne, go;

    function automatic logic [7:0] ref_byte(int i, bit xoff, logic [47:0] sa, logic [15:0] q);
        logic [7:0] da [6] = '{8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h01};
        if (i < 6)   return da[i];
        if (i < 12)  return sa[8*(11-i) +: 8];
        if (i == 12) return 8'h88;
        if (i == 13) return 8'h08;
        if (i == 14) return 8'h00;
        if (i == 15) return 8'h01;
        if (i == 16) return xoff ? q[15:8] : 8'h00;
        if (i == 17) return xoff ? q[7:0] : 8'h00;
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_q.delete();
            m_full_p = 0; m_xoff_p = 0; m_xon_p = 0; m_px = 0; m_pn = 0;
        end else begin
            was_busy = exp_q.size() > 0;
            if (was_busy) void'(exp_q.pop_front());
            go = !was_busy && (m_px || m_pn) && !tx_active;
            if (go) begin
                for (int i = 0; i < FLEN; i++)
                    exp_q.push_back(ref_byte(i, m_px, {station_hi, station_lo}, quanta_cfg));
                m_px = 0; m_pn = 0;
            end
            xl = cmd_xoff || req_xoff;
            nl = cmd_xon || req_xon;
            xe = (rxq_near_full && !m_full_p) || (xl && !m_xoff_p);
            ne = !xl && ((!rxq_near_full && m_full_p) || (nl && !m_xon_p));
            if (xe) begin m_px = 1; m_pn = 0; end
            else if (ne) begin m_pn = 1; m_px = 0; end
            m_full_p = rxq_near_full; m_xoff_p = xl; m_xon_p = nl;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        int sz;
        int bi;
        sz = exp_q.size();
        bi = FLEN - sz;
        chk(cur_req, "busy", int'(pf_busy), int'(sz > 0));
        chk("R10", "valid", int'(pf_valid), int'(sz > 0));
        chk("R6", "sop", int'(pf_sop), int'(sz == FLEN));
        chk("R6", "eop", int'(pf_eop), int'(sz == 1));
        if (sz > 0) chk(bi < 18 ? "R5" : "R6", "data", int'(pf_data), int'(exp_q[0]));
        else        chk("R1", "idle data", int'(pf_data), 0);
        if (pf_sop) begin frames++; obs_idx = 0; end
        else if (pf_busy) obs_idx++;
        if (pf_busy && obs_idx == 16) last_p1 = pf_data;
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_pins(bit x, bit n);
        @(negedge clk); req_xoff = x; req_xon = n;
        @(negedge clk); req_xoff = 0; req_xon = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int f0;
        cur_req = "R1";
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(4);

        cur_req = "R2"; f0 = frames;
        rxq_near_full = 1; wait_cyc(70);
        chk("R2", "xoff frames", frames - f0, 1);
        chk("R2", "xoff P1", int'(last_p1), 8'h12);

        cur_req = "R3"; f0 = frames;
        rxq_near_full = 0; wait_cyc(70);
        chk("R3", "xon frames", frames - f0, 1);
        chk("R3", "xon P1", int'(last_p1), 0);

        cur_req = "R4"; f0 = frames;
        tx_active = 1; rxq_near_full = 1; wait_cyc(15);
        chk("R4", "frames while tx active", frames - f0, 0);
        tx_active = 0; wait_cyc(70);
        chk("R4", "frames after tx done", frames - f0, 1);
        rxq_near_full = 0; wait_cyc(70);

        cur_req = "R7"; f0 = frames;
        quanta_cfg = 16'hFFEE; station_hi = 16'h5566; station_lo = 32'h7788_99AA;
        cmd_xoff = 1; wait_cyc(150);
        chk("R7", "cmd xoff frames", frames - f0, 1);
        chk("R9", "held level single frame", frames - f0, 1);

        cur_req = "R8"; f0 = frames;
        pulse_pins(0, 1); wait_cyc(70);
        chk("R8", "xon while xoff held", frames - f0, 0);
        cmd_xoff = 0; wait_cyc(2);
        cmd_xon = 1; wait_cyc(70); cmd_xon = 0;
        chk("R8", "xon after xoff cleared", frames - f0, 1);
        chk("R8", "xon P1", int'(last_p1), 0);

        f0 = frames;
        pulse_pins(1, 1); wait_cyc(70);
        chk("R8", "same-cycle frames", frames - f0, 1);
        chk("R8", "same-cycle is xoff", int'(last_p1), 8'hFF);

        cur_req = "R10"; f0 = frames;
        pulse_pins(1, 0); wait_cyc(10);
        pulse_pins(0, 1); wait_cyc(140);
        chk("R10", "back-to-back frames", frames - f0, 2);
        chk("R9", "queued xon sent", int'(last_p1), 0);

        wait_cyc(5);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule